// File: doc/BRIEF.md
# Shift-Register Counter Video Timing Generator

This block produces horizontal sync, vertical sync, display-enable and a frame marker for a raster display. It counts with 16-bit linear feedback shift registers instead of binary adders, so the next-state logic of each counter is a single XOR gate. Every compare value is therefore given as a state of the shift-register sequence, and each timing boundary is a plain 16-bit equality test.

Software, or a parent block, loads the ten compare values through a small write port. A write lands in a pending copy. The whole pending set moves into the active set on the clock edge that ends the last pixel of a frame, so a frame never mixes two timings. Before any write, the active set comes from binary timing parameters that are turned into sequence states at elaboration.

Top module: `lfsr_vtg`

## Requirements
- R1: While `rst_ni` is low, both counters hold the all-ones state, `hsync_o` and `vsync_o` sit at their inactive level, and `de_o` and `frame_o` are low.
- R2: The horizontal counter steps on every clock. On the clock after its state equals selector 0 (line wrap), it returns to all ones, so a compare value equal to the state after k steps gives lines k+1 clocks long.
- R3: One step shifts the state left by one bit, and the new bit 0 is the XOR of old bits 15, 4, 2 and 1. The compare value for count n is the state reached after n steps from 16'hFFFF.
- R4: The horizontal sync window covers the pixel positions from a match of selector 1 up to, but not including, a match of selector 2. If selector 2 is never reached within a line, the window closes at the line wrap.
- R5: The vertical counter steps only on a clock where the horizontal counter wraps. After the line whose vertical state equals selector 5 has ended, it returns to all ones.
- R6: The vertical sync window covers the lines from a match of selector 6 up to, but not including, a match of selector 7. A window may open on line 0.
- R7: `de_o` is high exactly when the horizontal active window (selector 3 to selector 4) and the vertical active window (selector 8 to selector 9) are both open. Both windows follow the same rules as in R4.
- R8: `frame_o` is high for one clock: the output cycle that belongs to pixel 0 of line 0.
- R9: All four outputs are registered together, and in any cycle they describe the position the counters held one clock earlier.
- R10: A write with `cfg_we_i` high stores `cfg_data_i` in the pending register named by `cfg_sel_i`. Pending values become active only at the edge where a frame ends, so the first frame after reset uses the parameter defaults.
- R11: A write with `cfg_sel_i` from 10 to 15 changes no timing.
- R12: With `SYNC_NEG` = 1, `hsync_o` and `vsync_o` are inverted, so they idle high and pulse low. `de_o` and `frame_o` keep their polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write strobe for the pending timing registers |
| cfg_sel_i | input | 4 | Register selector (0 to 9 valid) |
| cfg_data_i | input | 16 | Compare value as a shift-register state |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| frame_o | output | 1 | One-clock marker at the first pixel of a frame |

## Verification
The bench builds the block with `SYNC_NEG` = 1 and a 12-pixel by 6-line default frame. These small defaults make every frame only 72 clocks long, so the power-up timing, a mid-frame reprogramming and the point where it takes effect all fit within a short run. The inverted sync polarity is exercised from reset onward. Two later configurations bring in a 200-pixel line, which walks the sequence far from its seed, as well as windows that end past the wrap and a vertical window that opens on line 0.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
   localparam int LFSR_W   = 16;
   localparam int NUM_REGS = 10;
   localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

   // register selector values (order is decoded by the write port)
   typedef enum int {
      SEL_H_WRAP  = 0,
      SEL_HS_ON   = 1,
      SEL_HS_OFF  = 2,
      SEL_HA_ON   = 3,
      SEL_HA_OFF  = 4,
      SEL_V_WRAP  = 5,
      SEL_VS_ON   = 6,
      SEL_VS_OFF  = 7,
      SEL_VA_ON   = 8,
      SEL_VA_OFF  = 9
   } sel_e;

   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
   endfunction

   function automatic logic [LFSR_W-1:0] lfsr_after(input int unsigned n);
      logic [LFSR_W-1:0] v;
      v = LFSR_SEED;
      for (int unsigned i = 0; i < n; i++) v = lfsr_step(v);
      return v;
   endfunction
endpackage

// File: rtl/lfsr_vtg_cfg.sv
module lfsr_vtg_cfg #(
   parameter int W  = 16,
   parameter int N  = 10,
   parameter int SW = 4,
   parameter logic [N*W-1:0] RST_VAL = '0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                we_i,
   input  logic [SW-1:0]       sel_i,
   input  logic [W-1:0]        data_i,
   input  logic                apply_i,
   output logic [N-1:0][W-1:0] act_o
);
   if (N > (1 << SW)) begin : g_bad_sel
      $error("selector too narrow for register count");
   end

   for (genvar g = 0; g < N; g++) begin : g_reg
      logic [W-1:0] pend_q;
      logic [W-1:0] act_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            pend_q <= RST_VAL[g*W +: W];
            act_q  <= RST_VAL[g*W +: W];
         end else begin
            if (we_i && (sel_i == SW'(g))) pend_q <= data_i;
            if (apply_i) act_q <= pend_q;
         end
      end
      assign act_o[g] = act_q;
   end
endmodule

// File: rtl/lfsr_vtg_axis.sv
module lfsr_vtg_axis
   import lfsr_vtg_pkg::*;
#(
   parameter int W    = 16,
   parameter int NWIN = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   adv_i,
   input  logic [W-1:0]           wrap_cmp_i,
   input  logic [NWIN-1:0][W-1:0] on_i,
   input  logic [NWIN-1:0][W-1:0] off_i,
   output logic                   wrap_o,
   output logic                   first_o,
   output logic [W-1:0]           cnt_o,
   output logic [NWIN-1:0]        live_o
);
   if (W != LFSR_W) begin : g_bad_w
      $error("feedback taps are defined for a 16-bit state only");
   end

   logic [W-1:0] cnt_q;

   assign wrap_o  = (cnt_q == wrap_cmp_i);
   assign first_o = (cnt_q == LFSR_SEED);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    cnt_q <= LFSR_SEED;
      else if (adv_i) cnt_q <= wrap_o ? LFSR_SEED : lfsr_step(cnt_q);
   end

   // each window: opens on its start match, closes on its stop match,
   // and is forced shut when the counter wraps
   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic open_q;
      always_comb begin
         if (cnt_q == on_i[w])       live_o[w] = 1'b1;
         else if (cnt_q == off_i[w]) live_o[w] = 1'b0;
         else                        live_o[w] = open_q;
      end
      always_ff @(posedge clk_i) begin
         if (!rst_ni)    open_q <= 1'b0;
         else if (adv_i) open_q <= wrap_o ? 1'b0 : live_o[w];
      end
   end
endmodule

// File: rtl/lfsr_vtg.sv
module lfsr_vtg
   import lfsr_vtg_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit SYNC_NEG    = 1'b0,
   parameter int H_TOTAL     = 16,
   parameter int H_SYNC_W    = 2,
   parameter int H_ACT_START = 4,
   parameter int H_ACT_W     = 10,
   parameter int V_TOTAL     = 8,
   parameter int V_SYNC_W    = 1,
   parameter int V_ACT_START = 2,
   parameter int V_ACT_W     = 5,
   localparam int SEL_W      = $clog2(NUM_REGS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [SEL_W-1:0] cfg_sel_i,
   input  logic [CNT_W-1:0] cfg_data_i,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic             frame_o
);
   if (CNT_W != LFSR_W) begin : g_bad_width
      $error("CNT_W must match the shift-register width");
   end
   if (H_TOTAL < 2 || H_SYNC_W + 1 >= H_TOTAL || H_ACT_START + H_ACT_W > H_TOTAL) begin : g_bad_h
      $error("horizontal defaults out of range");
   end
   if (V_TOTAL < 1 || V_SYNC_W >= V_TOTAL || V_ACT_START + V_ACT_W > V_TOTAL) begin : g_bad_v
      $error("vertical defaults out of range");
   end

   localparam logic [NUM_REGS*CNT_W-1:0] RST_CFG = {
      lfsr_after(V_ACT_START + V_ACT_W),
      lfsr_after(V_ACT_START),
      lfsr_after(V_SYNC_W),
      lfsr_after(0),
      lfsr_after(V_TOTAL - 1),
      lfsr_after(H_ACT_START + H_ACT_W),
      lfsr_after(H_ACT_START),
      lfsr_after(1 + H_SYNC_W),
      lfsr_after(1),
      lfsr_after(H_TOTAL - 1)
   };

   logic [NUM_REGS-1:0][CNT_W-1:0] act;
   logic             line_wrap, frame_wrap;
   logic             h_wrap, v_wrap, h_first, v_first;
   logic [CNT_W-1:0] h_cnt, v_cnt;
   logic [1:0]       h_live, v_live;
   logic             hs_lvl, vs_lvl;

   assign line_wrap  = h_wrap;
   assign frame_wrap = h_wrap & v_wrap;

   lfsr_vtg_cfg #(
      .W(CNT_W), .N(NUM_REGS), .SW(SEL_W), .RST_VAL(RST_CFG)
   ) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
      .data_i(cfg_data_i), .apply_i(frame_wrap), .act_o(act)
   );

   // window 0 = sync, window 1 = active region
   lfsr_vtg_axis #(.W(CNT_W), .NWIN(2)) u_h (
      .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(1'b1),
      .wrap_cmp_i(act[SEL_H_WRAP]),
      .on_i({act[SEL_HA_ON], act[SEL_HS_ON]}),
      .off_i({act[SEL_HA_OFF], act[SEL_HS_OFF]}),
      .wrap_o(h_wrap), .first_o(h_first), .cnt_o(h_cnt), .live_o(h_live)
   );

   lfsr_vtg_axis #(.W(CNT_W), .NWIN(2)) u_v (
      .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(line_wrap),
      .wrap_cmp_i(act[SEL_V_WRAP]),
      .on_i({act[SEL_VA_ON], act[SEL_VS_ON]}),
      .off_i({act[SEL_VA_OFF], act[SEL_VS_OFF]}),
      .wrap_o(v_wrap), .first_o(v_first), .cnt_o(v_cnt), .live_o(v_live)
   );

   if (SYNC_NEG) begin : g_sync_neg
      assign hs_lvl = ~h_live[0];
      assign vs_lvl = ~v_live[0];
   end else begin : g_sync_pos
      assign hs_lvl = h_live[0];
      assign vs_lvl = v_live[0];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hsync_o <= SYNC_NEG;
         vsync_o <= SYNC_NEG;
         de_o    <= 1'b0;
         frame_o <= 1'b0;
      end else begin
         hsync_o <= hs_lvl;
         vsync_o <= vs_lvl;
         de_o    <= h_live[1] & v_live[1];
         frame_o <= h_first & v_first;
      end
   end
endmodule

// File: rtl/lfsr_vtg_chk.sv
module lfsr_vtg_chk #(
   parameter int W  = 16,
   parameter int NR = 10
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          line_wrap,
   input logic          frame_wrap,
   input logic          h_first,
   input logic [W-1:0]  hcnt,
   input logic [W-1:0]  vcnt,
   input logic [NR*W-1:0] act_flat,
   input logic          frame_o
);
   a_r2_line_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_wrap |=> h_first);

   a_r5_v_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_wrap |=> $stable(vcnt));

   a_r3_no_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hcnt != '0) && (vcnt != '0));

   a_r8_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_o |=> !frame_o);

   a_r8_frame_follows_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_wrap |=> ##1 frame_o);

   a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_wrap |=> $stable(act_flat));
endmodule

bind lfsr_vtg lfsr_vtg_chk #(.W(CNT_W), .NR(NUM_REGS)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .line_wrap(line_wrap),
   .frame_wrap(frame_wrap), .h_first(h_first), .hcnt(h_cnt), .vcnt(v_cnt),
   .act_flat(act), .frame_o(frame_o)
);

// File: tb/lfsr_vtg_bench.sv
module lfsr_vtg_bench;
   localparam int  NREG  = 10;
   localparam time CLK_P = 8ns;

   typedef struct {
      logic hs;
      logic vs;
      logic de;
      logic fr;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic        hsync, vsync, de, frame;

   int checks = 0;
   int errs   = 0;
   int mb_act [NREG];
   int mb_pend[NREG];
   int stg_sel = 0;
   int stg_val = 0;
   int x = 0, y = 0;
   exp_t q[$];
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   lfsr_vtg #(
      .SYNC_NEG(1'b1), .H_TOTAL(12), .H_SYNC_W(3), .H_ACT_START(5), .H_ACT_W(6),
      .V_TOTAL(6), .V_SYNC_W(2), .V_ACT_START(3), .V_ACT_W(2)
   ) u_lfsr_vtg (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
      .cfg_data_i(cfg_data), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
      .frame_o(frame)
   );

   // R3: state after n steps from all ones
   function automatic logic [15:0] lfsr_of(input int n);
      logic [15:0] v = 16'hFFFF;
      for (int i = 0; i < n; i++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
      return v;
   endfunction

   function automatic bit inside_win(input int p, input int a, input int b);
      return (p >= a) && (p < b);
   endfunction

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic cfg_write(input int sel, input int bin);
      @(negedge clk);
      stg_sel  = sel;
      stg_val  = bin;
      cfg_sel  = 4'(sel);
      cfg_data = lfsr_of(bin);
      cfg_we   = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // driver side: reference model pushes the expected outputs per position
   always @(posedge clk) begin
      if (rst_n) begin : model
         exp_t e;
         bit le, fe;
         e.hs = !inside_win(x, mb_act[1], mb_act[2]);  // inverted sync, R12
         e.vs = !inside_win(y, mb_act[6], mb_act[7]);
         e.de = inside_win(x, mb_act[3], mb_act[4]) && inside_win(y, mb_act[8], mb_act[9]);
         e.fr = (x == 0) && (y == 0);
         q.push_back(e);
         le = (x == mb_act[0]);
         fe = le && (y == mb_act[5]);
         if (fe) for (int i = 0; i < NREG; i++) mb_act[i] = mb_pend[i];
         if (cfg_we && stg_sel < NREG) mb_pend[stg_sel] = stg_val;
         if (le) begin
            x = 0;
            y = fe ? 0 : y + 1;
         end else begin
            x = x + 1;
         end
      end
   end

   // monitor side: outputs one clock behind the model position (R9)
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin : mon
         exp_t e;
         e = q.pop_front();
         chk("R2 R3 R4 R9 R12 hsync", hsync, e.hs);
         chk("R5 R6 R9 R12 vsync", vsync, e.vs);
         chk("R7 R9 de", de, e.de);
         chk("R8 R9 frame", frame, e.fr);
      end
   end

   initial begin
      // defaults as binary positions: wrap, hs on/off, ha on/off, vwrap, vs on/off, va on/off
      mb_act = '{11, 1, 4, 5, 11, 5, 0, 2, 3, 5};
      mb_pend = mb_act;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 R12: reset levels
      chk("R1 R12 hsync idle", hsync, 1'b1);
      chk("R1 R12 vsync idle", vsync, 1'b1);
      chk("R1 de low", de, 1'b0);
      chk("R1 frame low", frame, 1'b0);
      @(posedge clk);
      #2 rst_n = 1'b1;

      // first frames on parameter defaults (R10)
      repeat (100) @(negedge clk);

      // R10: reprogram mid-frame; takes effect at the next frame start
      cfg_write(0, 39);
      cfg_write(1, 1);
      cfg_write(2, 6);
      cfg_write(3, 8);
      cfg_write(4, 40);   // stop beyond the wrap: window closes at wrap (R4)
      // R11: unused selectors must not disturb anything
      cfg_write(10, 3);
      cfg_write(13, 0);
      cfg_write(15, 7);
      cfg_write(5, 4);
      cfg_write(6, 0);
      cfg_write(7, 1);
      cfg_write(8, 1);
      cfg_write(9, 4);
      repeat (700) @(negedge clk);

      // R3: long line walks deep into the sequence; R6 window from line 0
      cfg_write(0, 199);
      cfg_write(1, 1);
      cfg_write(2, 2);
      cfg_write(3, 20);
      cfg_write(4, 180);
      cfg_write(5, 2);
      cfg_write(6, 0);
      cfg_write(7, 3);
      cfg_write(8, 0);
      cfg_write(9, 3);
      cfg_write(11, 5);   // R11
      repeat (1500) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end
endmodule